// File: doc/BRIEF.md
# Two-Input Ordered-Arrival Detector

The detector watches two level inputs, x1 (`x[1]`) and x2 (`x[0]`), and reports on a two-bit output which of them went high first before both were high together. When x2 rises first and x1 follows, the output becomes `10`. When x1 rises first and x2 follows, the output becomes `01`. The result stays in place whatever the inputs do next, and clears only when both inputs are low again.

The block is a clocked form of a small fundamental-mode flow table. Each input passes through a two-flop synchronizer. A four-state register, updated once per clock, then follows the table. The state codes are arranged so that every move between states flips exactly one state bit. The output is decoded from the state and the synchronized inputs. A one-cycle error flag marks a sample in which both synchronized inputs changed at the same time. Even then, the table is applied to the new input.

Top module: `order_detect`

## Requirements
- R1: An asynchronous active-low reset puts the machine in its idle state: z = 00 and multi_change_err = 0. After reset, the sequence x1x2 = 01 then 11 gives z = 10.
- R2: Whenever the synchronized inputs are both low, z = 00. In the idle state with only x2 high (x1x2 = 01), z stays 00.
- R3: From idle, x1x2 = 01 followed by 11 (x2 first) drives z to 10.
- R4: Once z = 10, it holds 10 for any nonzero input (10, 01, 11 in any order) until x1x2 = 00, which gives z = 00.
- R5: From idle, x1x2 = 10 followed by 11 (x1 first) drives z to 01. It holds 01 for any nonzero input until x1x2 = 00.
- R6: After 01 is cleared by 00, the machine sits in a waiting state with z = 00. From there, input 10 keeps it waiting, 11 returns z to 01, and 01 sends it back to idle, so that a following 11 gives z = 10.
- R7: A change on `x` reaches the synchronized inputs on the second rising edge and the state on the third. A state-driven change of z is visible after the third edge and not after the second.
- R8: Every state change flips exactly one bit of the state code (idle=00, x2-first=01, waiting=10, x1-first=11), and z never reads 11.
- R9: If both synchronized inputs change in the same sample, multi_change_err is high for exactly one clock, aligned with the state update, and the table is still applied. From idle, 00 to 11 directly gives z = 10.
- R10: A change of a single input never raises multi_change_err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| x | input | 2 | Raw level inputs; `x[1]` is x1, `x[0]` is x2 |
| z | output | 2 | Arrival-order result; `z[1]` means x2 first, `z[0]` means x1 first |
| multi_change_err | output | 1 | One-cycle pulse when both inputs changed in one sample |

## Verification
The bench goes after the latching rule by cycling the inputs through every nonzero value while a result is held. A design that decoded the output from levels alone would drop the result to 00 or switch it there. It drives the path from the waiting state back to idle and the path from the waiting state back to x1-first, because a design that cleared the waiting state to idle would give the wrong result on the next 11. It also checks that the output is still 00 after the second edge and set after the third, which exposes a missing or extra synchronizer stage. Finally, it makes both inputs jump at once, to confirm that the flag is a single pulse and that the table still steps to the x2-first state.

// File: rtl/od_pkg.sv
package od_pkg;

  localparam int IN_W  = 2;
  localparam int OUT_W = 2;

  // Adjacent-code assignment: idle<->x2first, idle<->waiting, waiting<->x1first
  typedef enum logic [1:0] {
    ST_IDLE    = 2'b00,
    ST_X2FIRST = 2'b01,
    ST_WAIT    = 2'b10,
    ST_X1FIRST = 2'b11
  } od_state_e;

  // input coding is {x1, x2}
  function automatic od_state_e od_next(od_state_e s, logic [IN_W-1:0] xin);
    od_state_e n;
    n = s;
    unique case (s)
      ST_IDLE: begin
        if (xin == 2'b11)      n = ST_X2FIRST;
        else if (xin == 2'b10) n = ST_WAIT;
        else                   n = ST_IDLE;
      end
      ST_X2FIRST: n = (xin == 2'b00) ? ST_IDLE : ST_X2FIRST;
      ST_WAIT: begin
        if (xin == 2'b11)      n = ST_X1FIRST;
        else if (xin == 2'b01) n = ST_IDLE;
        else                   n = ST_WAIT;
      end
      ST_X1FIRST: n = (xin == 2'b00) ? ST_WAIT : ST_X1FIRST;
      default: n = ST_IDLE;
    endcase
    return n;
  endfunction

  function automatic logic [OUT_W-1:0] od_out(od_state_e s, logic [IN_W-1:0] xin);
    logic active;
    active = |xin;
    if (s == ST_X2FIRST && active)      return 2'b10;
    else if (s == ST_X1FIRST && active) return 2'b01;
    else                                return 2'b00;
  endfunction

  function automatic logic od_multi(logic [IN_W-1:0] now_v, logic [IN_W-1:0] was_v);
    return &(now_v ^ was_v);
  endfunction

endpackage

// File: rtl/od_sync.sv
module od_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] pipe [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe[0] <= '0;
    else        pipe[0] <= din;
  end

  generate
    for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[i] <= '0;
        else        pipe[i] <= pipe[i-1];
      end
    end
  endgenerate

  assign dout = pipe[STAGES-1];

endmodule

// File: rtl/od_state.sv
module od_state
  import od_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [IN_W-1:0] xs,
  output od_state_e       state,
  output logic            multi_err
);

  od_state_e       state_q, state_d;
  logic [IN_W-1:0] xs_prev;
  logic            both_moved;

  assign state_d    = od_next(state_q, xs);
  assign both_moved = od_multi(xs, xs_prev);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      xs_prev   <= '0;
      multi_err <= 1'b0;
    end else begin
      state_q   <= state_d;
      xs_prev   <= xs;
      multi_err <= both_moved;
    end
  end

  assign state = state_q;

  // R8
  state_hop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(state_q ^ $past(state_q)) <= 1);

  // R4
  x2_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_X2FIRST && xs != 2'b00) |=> state_q == ST_X2FIRST);

  // R5
  x1_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_X1FIRST && xs != 2'b00) |=> state_q == ST_X1FIRST);

  // R10
  single_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(xs ^ xs_prev) < 2) |=> !multi_err);

endmodule

// File: rtl/od_outdec.sv
module od_outdec
  import od_pkg::*;
(
  input  od_state_e        state,
  input  logic [IN_W-1:0]  xs,
  output logic [OUT_W-1:0] z
);

  assign z = od_out(state, xs);

  // R8
  always_comb begin
    z_code_chk: assert ($onehot0(z));
  end

endmodule

// File: rtl/order_detect.sv
module order_detect
  import od_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] x,
  output logic [1:0] z,
  output logic       multi_change_err
);

  logic [IN_W-1:0] x_sync;
  od_state_e       cur_state;

  od_sync #(.WIDTH(IN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (x),
    .dout (x_sync)
  );

  od_state u_state (
    .clk      (clk),
    .rst_n    (rst_n),
    .xs       (x_sync),
    .state    (cur_state),
    .multi_err(multi_change_err)
  );

  od_outdec u_dec (
    .state(cur_state),
    .xs   (x_sync),
    .z    (z)
  );

  // R2
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (x_sync == 2'b00) |-> (z == 2'b00));

endmodule

// File: tb/sim_order_detect.sv
module sim_order_detect;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] x = 2'b00;
  logic [1:0] z;
  logic       multi_change_err;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  order_detect u0 (
    .clk(clk), .rst_n(rst_n), .x(x), .z(z), .multi_change_err(multi_change_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  // apply a value and wait until it has passed sync and state register
  task automatic drive(input logic [1:0] v, output logic saw_err);
    saw_err = 1'b0;
    @(negedge clk);
    x = v;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (multi_change_err) saw_err = 1'b1;
    end
  endtask

  task automatic do_reset();
    x = 2'b00;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic e;
    rst_n = 1'b0;
    #1;
    chk("R1 z in reset", z, 2'b00);
    chk("R1 err in reset", {1'b0, multi_change_err}, 2'b00);
    do_reset();
    drive(2'b01, e);
    drive(2'b11, e);
    chk("R1 idle after reset", z, 2'b10);
  endtask

  task automatic t_x2_first();
    logic e;
    do_reset();
    drive(2'b01, e);
    chk("R2 idle with x2 only", z, 2'b00);
    chk("R10 no err single", {1'b0, e}, 2'b00);
    drive(2'b11, e);
    chk("R3 x2 first", z, 2'b10);
    drive(2'b10, e);
    chk("R4 hold on 10", z, 2'b10);
    drive(2'b11, e);
    chk("R4 hold on 11", z, 2'b10);
    drive(2'b01, e);
    chk("R4 hold on 01", z, 2'b10);
    chk("R10 no err walk", {1'b0, e}, 2'b00);
    drive(2'b00, e);
    chk("R4 clear", z, 2'b00);
    chk("R2 zero input", z, 2'b00);
  endtask

  task automatic t_x1_first();
    logic e;
    do_reset();
    drive(2'b10, e);
    chk("R5 pending", z, 2'b00);
    // latency: 11 applied, look after edge 2 and edge 3
    @(negedge clk);
    x = 2'b11;
    @(negedge clk);
    @(negedge clk);
    chk("R7 not yet after edge 2", z, 2'b00);
    @(negedge clk);
    chk("R7 set after edge 3", z, 2'b01);
    @(negedge clk);
    drive(2'b01, e);
    chk("R5 hold on 01", z, 2'b01);
    drive(2'b10, e);
    chk("R5 hold on 10", z, 2'b01);
    drive(2'b00, e);
    chk("R5 clear", z, 2'b00);
    // now waiting state
    drive(2'b10, e);
    chk("R6 wait on 10", z, 2'b00);
    drive(2'b11, e);
    chk("R6 wait to x1 first", z, 2'b01);
    drive(2'b00, e);
    drive(2'b01, e);
    chk("R6 wait to idle", z, 2'b00);
    drive(2'b11, e);
    chk("R6 idle then 11", z, 2'b10);
    chk("R10 no err", {1'b0, e}, 2'b00);
  endtask

  task automatic t_double();
    do_reset();
    @(negedge clk);
    x = 2'b11;
    @(negedge clk);
    chk("R9 no err edge 1", {1'b0, multi_change_err}, 2'b00);
    @(negedge clk);
    chk("R9 no err edge 2", {1'b0, multi_change_err}, 2'b00);
    @(negedge clk);
    chk("R9 err pulse", {1'b0, multi_change_err}, 2'b01);
    chk("R9 table applied", z, 2'b10);
    @(negedge clk);
    chk("R9 err one cycle", {1'b0, multi_change_err}, 2'b00);
    chk("R9 result held", z, 2'b10);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_x2_first();
    t_x1_first();
    t_double();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule